// File: doc/BRIEF.md
# CAN Transmit Buffer Flag Controller

This block keeps the empty or full state of three transmit message buffers in a CAN controller. It also holds the per-buffer interrupt enables and the abort request and acknowledge bits. A CPU reaches it through a simple register bus. Writing a one to an empty flag hands that buffer to the transmit engine. The engine reports back with per-buffer pulses for a completed send and for a completed abort.

The flags are write-one-to-clear, and they are tied to the abort bits. A flag that becomes set drops the buffer's pending abort request. Clearing a flag drops its abort acknowledge. In listen mode the CPU cannot clear a flag and no buffer is offered for transmission. While the controller is in initialization mode, the flag and abort state is held at its reset value. A registered interrupt line is raised whenever an enabled buffer is empty. A per-buffer blocked signal tells the buffer storage to refuse CPU access while a buffer is queued.

Top module: `can_txbuf_flags`

## Requirements
- R1: After reset the empty flags read 3'b111. The enable, abort request and abort acknowledge registers read 3'b000, and irq_o is 0.
- R2: A write to address 0 clears every flag whose data bit (bits 2..0) is 1 and leaves a flag alone where the bit is 0. Bits 7..3 of address 0 read 0.
- R3: A tx_done_i pulse on a buffer sets that buffer's flag at the next clock edge.
- R4: A write to address 2 sets the abort request of each buffer whose data bit is 1, but only for buffers whose flag is 0. When abort_done_i arrives for a buffer with a pending request, that buffer's flag and abort acknowledge are set. Without a pending request, abort_done_i is ignored.
- R5: At the edge where a flag becomes set, for any reason, that buffer's abort request is cleared.
- R6: Clearing a flag through the bus also clears that buffer's abort acknowledge.
- R7: While listen_i is 1, flag clear writes have no effect and sched_o is 3'b000.
- R8: While init_rq_i and init_ak_i are both 1, the flags are held at 1 and the abort bits at 0. Writes to addresses 0 and 2 are ignored unless init_rq_i and init_ak_i are both 0.
- R9: If a clear write and a hardware set event hit the same flag in the same cycle, the flag ends up set.
- R10: irq_o equals the OR over the buffers of (flag AND enable), taken from the previous cycle. The enables sit in bits 2..0 of address 1 and are writable at any time.
- R11: sched_o is the inverted flag vector gated by not-listen, and buf_blocked_o is 1 for a buffer whose flag is 0 and which is scheduled.
- R12: Address 3 returns the abort acknowledge bits and is read-only. Other addresses read 0, and bus_rdata_o is 0 while bus_re_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| init_rq_i | input | 1 | Initialization mode request |
| init_ak_i | input | 1 | Initialization mode acknowledge |
| listen_i | input | 1 | Listen-only mode |
| bus_re_i | input | 1 | Register read strobe |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 3 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data |
| tx_done_i | input | 3 | Per-buffer pulse: message sent |
| abort_done_i | input | 3 | Per-buffer pulse: abort completed |
| sched_o | output | 3 | Buffers offered to the transmit engine |
| buf_blocked_o | output | 3 | Per-buffer CPU access block |
| irq_o | output | 1 | Transmit interrupt request |

## Verification
The bench aims at the cross-coupling of the flags and the abort bits.

If the request were not dropped on a completed send, the request bit would stay stuck high. An abort completion that arrives without a request must be ignored; a design that accepts it would set a flag that should stay clear. An abort request written to an empty buffer must be ignored as well, and a design that accepts it would show a stray request.

When a clear and a completion land on the same flag in the same cycle, a design where the clear wins would show the buffer as full and lose the completion. The listen and initialization interlocks are also tested in the half-entered initialization state, where a careless decode would still accept writes. Finally, the bench checks the one-cycle lag of the interrupt line, which a combinational interrupt would get wrong by one cycle.

// File: rtl/can_txb_pkg.sv
package can_txb_pkg;
  localparam int unsigned ADDR_FLAG  = 0;
  localparam int unsigned ADDR_IEN   = 1;
  localparam int unsigned ADDR_ARQ   = 2;
  localparam int unsigned ADDR_AAK   = 3;
endpackage

// File: rtl/can_txb_bus_if.sv
module can_txb_bus_if
  import can_txb_pkg::*;
#(
  parameter int unsigned NUM_BUF = 3,
  parameter int unsigned ADDR_W  = 3,
  parameter int unsigned DATA_W  = 8
) (
  input  logic              re_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              writable_i,
  input  logic              listen_i,
  input  logic [NUM_BUF-1:0] txe_i,
  input  logic [NUM_BUF-1:0] ien_i,
  input  logic [NUM_BUF-1:0] arq_i,
  input  logic [NUM_BUF-1:0] aak_i,
  output logic [NUM_BUF-1:0] clr_o,
  output logic [NUM_BUF-1:0] rq_set_o,
  output logic               ien_we_o,
  output logic [NUM_BUF-1:0] ien_wdata_o,
  output logic [DATA_W-1:0]  rdata_o
);
  localparam int unsigned PAD_W = DATA_W - NUM_BUF;

  logic hit_flag, hit_ien, hit_arq, hit_aak;

  always_comb begin
    hit_flag = (addr_i == ADDR_W'(ADDR_FLAG));
    hit_ien  = (addr_i == ADDR_W'(ADDR_IEN));
    hit_arq  = (addr_i == ADDR_W'(ADDR_ARQ));
    hit_aak  = (addr_i == ADDR_W'(ADDR_AAK));
  end

  // flag clears need a writable register and no listen mode
  assign clr_o       = {NUM_BUF{we_i & hit_flag & writable_i & ~listen_i}} & wdata_i[NUM_BUF-1:0];
  assign rq_set_o    = {NUM_BUF{we_i & hit_arq & writable_i}} & wdata_i[NUM_BUF-1:0];
  assign ien_we_o    = we_i & hit_ien;
  assign ien_wdata_o = wdata_i[NUM_BUF-1:0];

  always_comb begin
    rdata_o = '0;
    if (re_i) begin
      if (hit_flag)     rdata_o = {{PAD_W{1'b0}}, txe_i};
      else if (hit_ien) rdata_o = {{PAD_W{1'b0}}, ien_i};
      else if (hit_arq) rdata_o = {{PAD_W{1'b0}}, arq_i};
      else if (hit_aak) rdata_o = {{PAD_W{1'b0}}, aak_i};
    end
  end
endmodule

// File: rtl/can_txb_slice.sv
module can_txb_slice (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_i,
  input  logic clr_i,
  input  logic rq_set_i,
  input  logic tx_done_i,
  input  logic abort_done_i,
  output logic txe_o,
  output logic arq_o,
  output logic aak_o
);
  logic abort_ok, set_ev;

  assign abort_ok = abort_done_i & arq_o;
  assign set_ev   = tx_done_i | abort_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      txe_o <= 1'b1;
      arq_o <= 1'b0;
      aak_o <= 1'b0;
    end else if (hold_i) begin
      txe_o <= 1'b1;
      arq_o <= 1'b0;
      aak_o <= 1'b0;
    end else begin
      // hardware set beats a same-cycle clear
      txe_o <= set_ev | (txe_o & ~clr_i);
      arq_o <= set_ev ? 1'b0 : (arq_o | (rq_set_i & ~txe_o));
      if (abort_ok)                aak_o <= 1'b1;
      else if (clr_i && txe_o && !set_ev) aak_o <= 1'b0;
    end
  end
endmodule

// File: rtl/can_txb_irq.sv
module can_txb_irq #(
  parameter int unsigned NUM_BUF = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [NUM_BUF-1:0] wdata_i,
  input  logic [NUM_BUF-1:0] txe_i,
  output logic [NUM_BUF-1:0] ien_o,
  output logic               irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ien_o <= '0;
      irq_o <= 1'b0;
    end else begin
      if (we_i) ien_o <= wdata_i;
      irq_o <= |(txe_i & ien_o);
    end
  end
endmodule

// File: rtl/can_txbuf_flags.sv
module can_txbuf_flags #(
  parameter int unsigned NUM_BUF = 3,
  parameter int unsigned ADDR_W  = 3,
  parameter int unsigned DATA_W  = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               init_rq_i,
  input  logic               init_ak_i,
  input  logic               listen_i,
  input  logic               bus_re_i,
  input  logic               bus_we_i,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic [DATA_W-1:0]  bus_wdata_i,
  output logic [DATA_W-1:0]  bus_rdata_o,
  input  logic [NUM_BUF-1:0] tx_done_i,
  input  logic [NUM_BUF-1:0] abort_done_i,
  output logic [NUM_BUF-1:0] sched_o,
  output logic [NUM_BUF-1:0] buf_blocked_o,
  output logic               irq_o
);
  logic               hold, writable, ien_we;
  logic [NUM_BUF-1:0] txe_q, arq_q, aak_q, ien_q;
  logic [NUM_BUF-1:0] clr, rq_set, ien_wdata;

  assign hold     = init_rq_i & init_ak_i;
  assign writable = ~init_rq_i & ~init_ak_i;

  can_txb_bus_if #(
    .NUM_BUF(NUM_BUF), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_bus (
    .re_i        (bus_re_i),
    .we_i        (bus_we_i),
    .addr_i      (bus_addr_i),
    .wdata_i     (bus_wdata_i),
    .writable_i  (writable),
    .listen_i    (listen_i),
    .txe_i       (txe_q),
    .ien_i       (ien_q),
    .arq_i       (arq_q),
    .aak_i       (aak_q),
    .clr_o       (clr),
    .rq_set_o    (rq_set),
    .ien_we_o    (ien_we),
    .ien_wdata_o (ien_wdata),
    .rdata_o     (bus_rdata_o)
  );

  for (genvar g = 0; g < NUM_BUF; g++) begin : g_buf
    can_txb_slice u_slice (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .hold_i       (hold),
      .clr_i        (clr[g]),
      .rq_set_i     (rq_set[g]),
      .tx_done_i    (tx_done_i[g]),
      .abort_done_i (abort_done_i[g]),
      .txe_o        (txe_q[g]),
      .arq_o        (arq_q[g]),
      .aak_o        (aak_q[g])
    );
  end

  can_txb_irq #(.NUM_BUF(NUM_BUF)) u_irq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (ien_we),
    .wdata_i (ien_wdata),
    .txe_i   (txe_q),
    .ien_o   (ien_q),
    .irq_o   (irq_o)
  );

  assign sched_o       = ~txe_q & {NUM_BUF{~listen_i}};
  assign buf_blocked_o = ~txe_q & sched_o;
endmodule

// File: rtl/can_txbuf_flags_chk.sv
module can_txbuf_flags_chk #(
  parameter int unsigned NUM_BUF = 3
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               init_rq_i,
  input logic               init_ak_i,
  input logic               listen_i,
  input logic [NUM_BUF-1:0] tx_done_i,
  input logic [NUM_BUF-1:0] txe_q,
  input logic [NUM_BUF-1:0] arq_q,
  input logic [NUM_BUF-1:0] aak_q,
  input logic [NUM_BUF-1:0] ien_q,
  input logic               irq_o
);
  p_init_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (init_rq_i && init_ak_i) |=> (txe_q == '1 && arq_q == '0 && aak_q == '0));

  p_listen_keep_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    listen_i |=> ((txe_q & $past(txe_q)) == $past(txe_q)));

  p_done_sets_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_done_i != '0) |=> ((txe_q & $past(tx_done_i)) == $past(tx_done_i)));

  p_rq_only_full_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arq_q & txe_q) == '0);

  p_rise_drops_rq_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((txe_q & ~$past(txe_q)) & arq_q) == '0);

  p_fall_drops_ak_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((~txe_q & $past(txe_q)) & aak_q) == '0);

  p_irq_lag_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == $past(|(txe_q & ien_q)));
endmodule

bind can_txbuf_flags can_txbuf_flags_chk #(.NUM_BUF(NUM_BUF)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .init_rq_i (init_rq_i),
  .init_ak_i (init_ak_i),
  .listen_i  (listen_i),
  .tx_done_i (tx_done_i),
  .txe_q     (txe_q),
  .arq_q     (arq_q),
  .aak_q     (aak_q),
  .ien_q     (ien_q),
  .irq_o     (irq_o)
);

// File: tb/tb_can_txbuf_flags.sv
`timescale 1ns/100ps
module tb_can_txbuf_flags;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       init_rq_i = 1'b0, init_ak_i = 1'b0, listen_i = 1'b0;
  logic       bus_re_i = 1'b0, bus_we_i = 1'b0;
  logic [2:0] bus_addr_i = '0;
  logic [7:0] bus_wdata_i = '0;
  logic [7:0] bus_rdata_o;
  logic [2:0] tx_done_i = '0, abort_done_i = '0;
  logic [2:0] sched_o, buf_blocked_o;
  logic       irq_o;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk_i = ~clk_i;

  can_txbuf_flags dut (.*);

  typedef struct packed {
    logic       we;
    logic [2:0] addr;
    logic [7:0] wd;
    logic [2:0] done;
    logic [2:0] abrt;
    logic       lst;
    logic [2:0] e_txe;
    logic [2:0] e_arq;
    logic [2:0] e_aak;
    logic       e_irq;
    logic [7:0] tag;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 3'd1, 8'h05, 3'b000, 3'b000, 1'b0, 3'b111, 3'b000, 3'b000, 1'b1, 8'd10}, // R10 enable
    '{1'b1, 3'd0, 8'hFA, 3'b000, 3'b000, 1'b0, 3'b101, 3'b000, 3'b000, 1'b1, 8'd2},  // R2 one bit
    '{1'b1, 3'd0, 8'h05, 3'b000, 3'b000, 1'b0, 3'b000, 3'b000, 3'b000, 1'b0, 8'd2},  // R2 rest
    '{1'b1, 3'd2, 8'h03, 3'b000, 3'b000, 1'b0, 3'b000, 3'b011, 3'b000, 1'b0, 8'd4},  // R4 request
    '{1'b0, 3'd0, 8'h00, 3'b000, 3'b001, 1'b0, 3'b001, 3'b010, 3'b001, 1'b1, 8'd4},  // R4 abort ok
    '{1'b0, 3'd0, 8'h00, 3'b010, 3'b000, 1'b0, 3'b011, 3'b000, 3'b001, 1'b1, 8'd5},  // R5 via send
    '{1'b1, 3'd0, 8'h01, 3'b000, 3'b000, 1'b0, 3'b010, 3'b000, 3'b000, 1'b0, 8'd6},  // R6
    '{1'b0, 3'd0, 8'h00, 3'b000, 3'b100, 1'b0, 3'b010, 3'b000, 3'b000, 1'b0, 8'd4},  // R4 stray abort
    '{1'b1, 3'd2, 8'h02, 3'b000, 3'b000, 1'b0, 3'b010, 3'b000, 3'b000, 1'b0, 8'd4},  // R4 rq on empty
    '{1'b1, 3'd0, 8'h02, 3'b000, 3'b000, 1'b1, 3'b010, 3'b000, 3'b000, 1'b0, 8'd7},  // R7
    '{1'b1, 3'd0, 8'h02, 3'b010, 3'b000, 1'b0, 3'b010, 3'b000, 3'b000, 1'b0, 8'd9},  // R9
    '{1'b1, 3'd0, 8'h02, 3'b000, 3'b000, 1'b0, 3'b000, 3'b000, 3'b000, 1'b0, 8'd2},
    '{1'b1, 3'd2, 8'h04, 3'b000, 3'b000, 1'b0, 3'b000, 3'b100, 3'b000, 1'b0, 8'd4},
    '{1'b0, 3'd0, 8'h00, 3'b100, 3'b000, 1'b0, 3'b100, 3'b000, 3'b000, 1'b1, 8'd3}   // R3 / R5
  };

  task automatic check(input string req, input string what, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    bus_re_i = 1'b1;
    bus_addr_i = a;
    #0.2;
    d = bus_rdata_o;
    bus_re_i = 1'b0;
  endtask

  task automatic check_state(input string req, input logic [2:0] txe, input logic [2:0] arq,
                             input logic [2:0] aak);
    logic [7:0] d;
    rd(3'd0, d); check(req, "flags", d, {5'b0, txe});
    rd(3'd2, d); check(req, "abort req", d, {5'b0, arq});
    rd(3'd3, d); check(req, "abort ack", d, {5'b0, aak});
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] v);
    bus_we_i = 1'b1; bus_addr_i = a; bus_wdata_i = v;
    @(negedge clk_i);
    bus_we_i = 1'b0; bus_wdata_i = '0;
  endtask

  initial begin
    repeat (5000) @(posedge clk_i);
    n_err++;
    n_chk++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    check_state("R1", 3'b111, 3'b000, 3'b000);
    rd(3'd1, d); check("R1", "enable", d, 8'h00);
    check("R1", "irq", {7'b0, irq_o}, 8'h00);
    check("R11", "sched reset", {5'b0, sched_o}, 8'h00);

    foreach (TBL[i]) begin
      bus_we_i = TBL[i].we; bus_addr_i = TBL[i].addr; bus_wdata_i = TBL[i].wd;
      tx_done_i = TBL[i].done; abort_done_i = TBL[i].abrt; listen_i = TBL[i].lst;
      @(negedge clk_i);
      bus_we_i = 1'b0; bus_wdata_i = '0; tx_done_i = '0; abort_done_i = '0; listen_i = 1'b0;
      @(negedge clk_i);
      check_state($sformatf("R%0d", TBL[i].tag), TBL[i].e_txe, TBL[i].e_arq, TBL[i].e_aak);
      check($sformatf("R%0d", TBL[i].tag), "irq", {7'b0, irq_o}, {7'b0, TBL[i].e_irq});
    end

    // R12 address map and read strobe
    rd(3'd5, d); check("R12", "unmapped", d, 8'h00);
    bus_addr_i = 3'd0; #0.2;
    check("R12", "re low", bus_rdata_o, 8'h00);
    wr(3'd3, 8'h07);
    check_state("R12", 3'b100, 3'b000, 3'b000);

    // R11 schedule and block
    #0.2;
    check("R11", "sched", {5'b0, sched_o}, 8'h03);
    check("R11", "blocked", {5'b0, buf_blocked_o}, 8'h03);
    listen_i = 1'b1; #0.2;
    check("R7", "sched listen", {5'b0, sched_o}, 8'h00);
    check("R11", "blocked listen", {5'b0, buf_blocked_o}, 8'h00);
    listen_i = 1'b0;

    // R8 half-entered init: writes ignored
    init_rq_i = 1'b1;
    wr(3'd0, 8'h04);
    check_state("R8", 3'b100, 3'b000, 3'b000);
    init_ak_i = 1'b1;
    wr(3'd0, 8'h07);
    check_state("R8", 3'b111, 3'b000, 3'b000);
    init_rq_i = 1'b0; init_ak_i = 1'b0;
    wr(3'd0, 8'h01);
    check_state("R8", 3'b110, 3'b000, 3'b000);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule